// File: doc/BRIEF.md
# Multichannel Pulse-Width Modulator with Deferred Reload

A bank of independent pulse-width modulator channels behind a small word-addressed register bus. Each channel has a period, a duty value, a power-of-two prescaler and an output polarity. A channel is configured while stopped, where its period and duty writes land immediately. It is started and stopped through two shared bit-mask registers. While a channel runs, its period and duty are frozen against direct writes. The only way to change them is one per-channel reload register. Its value is held and copied into either period or duty at the next wrap of the channel counter. A target bit in the channel's mode word selects which of the two receives it.

Each applied reload sets that channel's bit in a shared completion register. Software polls this register, and reading it clears it. Period and duty changes made through the reload path are independent events, so they may land in different periods. Only one reload per channel is held at a time.

Top module: `pwm_multi`

## Requirements
- R1: After reset every channel is stopped, every output is low, the completion register reads 0 and the running mask reads 0.
- R2: Writing 1 to bit n at word address 0 starts channel n, and writing 1 to bit n at address 1 stops it. Reading either address returns the running mask. A stopped channel holds its output at its idle level.
- R3: A running channel's counter steps 0, 1, ..., period-1 and wraps. The output is active while the count is below duty. A duty of 0 gives a constant inactive level, and a duty of period or more gives a constant active level.
- R4: The counter advances once every 2^p input clocks, where p is mode bits 3:0. A p code above PRES_MAX (10) is stored as PRES_MAX.
- R5: Mode bit 8 set inverts the output, including the idle level of a stopped channel.
- R6: Each channel n has a group of registers at base 8+4n: mode at +0, period at +1, duty at +2 and reload at +3. While the channel is stopped, writes to period, duty or reload (into the target chosen by mode bit 10) take effect on the next cycle.
- R7: While a channel runs, direct period and duty writes are ignored, and the prescaler and polarity fields of a mode write are ignored. The target bit is still accepted.
- R8: A reload write to a running channel is held. At the next counter wrap it is copied into duty when mode bit 10 was 0 at write time, or into period when it was 1. A later reload write before that wrap replaces the held value.
- R9: Word address 2 is the completion register. Bit n is set when a held reload of channel n is applied. A read returns the flags one cycle later and clears them, and a flag set in the cycle of the read survives. A reload applied directly to a stopped channel sets no flag.
- R10: Stopping a channel discards its held reload, so it is never applied.
- R11: Read data appears on the bus one cycle after the read strobe, and stays unchanged until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| pwm_o | output | 4 | One modulated output per channel |

## Verification
The assertions take for granted that a read strobe and a write strobe never come in the same cycle. They also take for granted that no channel is started and stopped in one cycle, which a single address bus already prevents. The bench drives one bus operation per cycle, always at the falling clock edge, so both hold. Stimulus places reload writes far from the counter wrap by using a 16-clock prescale step. A held value is therefore observed before its wrap and again after it, and waveform checks count active cycles over whole periods, so the phase of the count does not matter.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int GLB_ENA  = 0;
  localparam int GLB_DIS  = 1;
  localparam int GLB_STAT = 2;
  localparam int CH_GRP_BASE  = 2;
  localparam int MODE_POL_BIT = 8;
  localparam int MODE_TGT_BIT = 10;

  typedef enum logic [1:0] {
    OFS_MODE = 2'd0,
    OFS_PRD  = 2'd1,
    OFS_DTY  = 2'd2,
    OFS_UPD  = 2'd3
  } ch_ofs_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRES_W   = 4,
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [PRES_W-1:0] pres_i,
  output logic              tick_o
);
  logic [PRES_MAX-1:0] div_q, div_d, mask;

  always_comb begin
    for (int i = 0; i < PRES_MAX; i++) mask[i] = (i < int'(pres_i));
  end

  assign tick_o = run_i && ((div_q & mask) == mask);

  always_comb begin
    div_d = div_q;
    if (clr_i)      div_d = '0;
    else if (run_i) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R4: with a non-zero prescale code, ticks never come on back-to-back cycles
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !clr_i && tick_o && (pres_i != '0) |=> !tick_o)
    else $error("a_r4_tick_spacing");
endmodule

// File: rtl/pwm_status.sv
module pwm_status #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              rd_clr_i,
  output logic [NUM_CH-1:0] flags_o
);
  logic [NUM_CH-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (rd_clr_i) flags_d = '0;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R9: a read leaves only the flags raised in that same cycle
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> ((flags_q & ~$past(set_i)) == '0))
    else $error("a_r9_read_clears");

  // R9: an applied reload is always recorded, read or not
  a_r9_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)))
    else $error("a_r9_flag_kept");
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W    = 16,
  parameter int PRES_W   = 4,
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_mode_i,
  input  logic              wr_prd_i,
  input  logic              wr_dty_i,
  input  logic              wr_upd_i,
  input  logic [CNT_W-1:0]  val_i,
  input  logic [PRES_W-1:0] mode_pres_i,
  input  logic              mode_pol_i,
  input  logic              mode_tgt_i,
  output logic              running_o,
  output logic              pwm_o,
  output logic              applied_o,
  output logic [CNT_W-1:0]  prd_o,
  output logic [CNT_W-1:0]  dty_o,
  output logic [PRES_W-1:0] pres_o,
  output logic              pol_o,
  output logic              tgt_o
);
  localparam logic [PRES_W-1:0] PRES_LIM = PRES_W'(PRES_MAX);

  logic              run_q, run_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  prd_q, prd_d, dty_q, dty_d, pv_q, pv_d;
  logic              pend_q, pend_d, pt_q, pt_d;
  logic [PRES_W-1:0] pres_q, pres_d;
  logic              pol_q, pol_d, tgt_q, tgt_d;
  logic              start_go, tick, last, boundary, applied;

  assign start_go = start_i && !run_q;

  pwm_prescaler #(.PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_pres (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .clr_i(start_go),
    .pres_i(pres_q), .tick_o(tick)
  );

  assign last     = (prd_q == '0) || (cnt_q >= prd_q - 1'b1);
  assign boundary = run_q && tick && last;
  assign applied  = boundary && pend_q && !stop_i;

  always_comb begin
    run_d  = run_q;  cnt_d = cnt_q;
    prd_d  = prd_q;  dty_d = dty_q;
    pv_d   = pv_q;   pend_d = pend_q; pt_d = pt_q;
    pres_d = pres_q; pol_d = pol_q;   tgt_d = tgt_q;

    if (start_go) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q && tick) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end

    if (applied) begin
      pend_d = 1'b0;
      if (pt_q) prd_d = pv_q;
      else      dty_d = pv_q;
    end

    if (run_q) begin
      if (wr_upd_i) begin
        pend_d = 1'b1;
        pv_d   = val_i;
        pt_d   = tgt_q;
      end
    end else begin
      if (wr_prd_i) prd_d = val_i;
      if (wr_dty_i) dty_d = val_i;
      if (wr_upd_i) begin
        if (tgt_q) prd_d = val_i;
        else       dty_d = val_i;
      end
    end

    if (wr_mode_i) begin
      tgt_d = mode_tgt_i;
      if (!run_q) begin
        pres_d = (mode_pres_i > PRES_LIM) ? PRES_LIM : mode_pres_i;
        pol_d  = mode_pol_i;
      end
    end

    if (stop_i) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; cnt_q <= '0; prd_q <= '0; dty_q <= '0;
      pv_q <= '0; pend_q <= 1'b0; pt_q <= 1'b0;
      pres_q <= '0; pol_q <= 1'b0; tgt_q <= 1'b0;
    end else begin
      run_q <= run_d; cnt_q <= cnt_d; prd_q <= prd_d; dty_q <= dty_d;
      pv_q <= pv_d; pend_q <= pend_d; pt_q <= pt_d;
      pres_q <= pres_d; pol_q <= pol_d; tgt_q <= tgt_d;
    end
  end

  assign pwm_o     = (run_q && (cnt_q < dty_q)) ^ pol_q;
  assign running_o = run_q;
  assign applied_o = applied;
  assign prd_o     = prd_q;
  assign dty_o     = dty_q;
  assign pres_o    = pres_q;
  assign pol_o     = pol_q;
  assign tgt_o     = tgt_q;

  // R3: a running count stays inside the period
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && (prd_q != '0) |-> cnt_q < prd_q)
    else $error("a_r3_count_in_range");

  // R7: prescaler and polarity are frozen while running
  a_r7_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(run_q) |-> $stable(pol_q) && $stable(pres_q))
    else $error("a_r7_mode_locked");

  // R8: a reload write to a running channel never lands on its own edge
  a_r8_update_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    wr_upd_i && run_q && !applied |=> $stable(prd_q) && $stable(dty_q))
    else $error("a_r8_update_deferred");

  // R10: stopping drops the held reload and the run state
  a_r10_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !run_q && !pend_q)
    else $error("a_r10_stop_drops");
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi #(
  parameter int NUM_CH   = 4,
  parameter int CNT_W    = 16,
  parameter int PRES_W   = 4,
  parameter int PRES_MAX = 10,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  import pwm_pkg::*;

  localparam int GRP_W = ADDR_W - 2;

  logic [GRP_W-1:0] grp;
  logic [1:0]       ofs;
  logic             glb_sel;
  logic [NUM_CH-1:0] start_v, stop_v, running, applied, flags;
  logic [NUM_CH-1:0][CNT_W-1:0]  prd_a, dty_a;
  logic [NUM_CH-1:0][PRES_W-1:0] pres_a;
  logic [NUM_CH-1:0] pol_a, tgt_a;
  logic [DATA_W-1:0] rd_d, rdata_q;
  logic              stat_rd;
  logic              unused_wdata;

  assign grp     = bus_addr_i[ADDR_W-1:2];
  assign ofs     = bus_addr_i[1:0];
  assign glb_sel = (grp == '0);
  assign start_v = {NUM_CH{bus_wr_i && glb_sel && (ofs == 2'(GLB_ENA))}} & bus_wdata_i[NUM_CH-1:0];
  assign stop_v  = {NUM_CH{bus_wr_i && glb_sel && (ofs == 2'(GLB_DIS))}} & bus_wdata_i[NUM_CH-1:0];
  assign stat_rd = bus_rd_i && glb_sel && (ofs == 2'(GLB_STAT));
  assign unused_wdata = ^bus_wdata_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = bus_wr_i && (grp == GRP_W'(CH_GRP_BASE + g));

    pwm_channel #(.CNT_W(CNT_W), .PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .start_i(start_v[g]), .stop_i(stop_v[g]),
      .wr_mode_i(sel && (ofs == OFS_MODE)),
      .wr_prd_i (sel && (ofs == OFS_PRD)),
      .wr_dty_i (sel && (ofs == OFS_DTY)),
      .wr_upd_i (sel && (ofs == OFS_UPD)),
      .val_i(bus_wdata_i[CNT_W-1:0]),
      .mode_pres_i(bus_wdata_i[PRES_W-1:0]),
      .mode_pol_i(bus_wdata_i[MODE_POL_BIT]),
      .mode_tgt_i(bus_wdata_i[MODE_TGT_BIT]),
      .running_o(running[g]), .pwm_o(pwm_o[g]), .applied_o(applied[g]),
      .prd_o(prd_a[g]), .dty_o(dty_a[g]), .pres_o(pres_a[g]),
      .pol_o(pol_a[g]), .tgt_o(tgt_a[g])
    );
  end

  pwm_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(applied), .rd_clr_i(stat_rd), .flags_o(flags)
  );

  always_comb begin
    rd_d = '0;
    if (glb_sel) begin
      if (ofs == 2'(GLB_STAT)) rd_d = DATA_W'(flags);
      else if (ofs != 2'd3)    rd_d = DATA_W'(running);
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (grp == GRP_W'(CH_GRP_BASE + i)) begin
        case (ofs)
          OFS_MODE: begin
            rd_d[PRES_W-1:0]   = pres_a[i];
            rd_d[MODE_POL_BIT] = pol_a[i];
            rd_d[MODE_TGT_BIT] = tgt_a[i];
          end
          OFS_PRD: rd_d = DATA_W'(prd_a[i]);
          OFS_DTY: rd_d = DATA_W'(dty_a[i]);
          default: rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_d;
  end

  assign bus_rdata_o = rdata_q;

  // R11: read data holds between reads
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd_i) |-> $stable(bus_rdata_o))
    else $error("a_r11_rdata_hold");
endmodule

// File: tb/tb_pwm_multi.sv
module tb_pwm_multi;
  logic        clk, rst_n, wr, rd, rd_pend;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  logic [3:0]  pwm;
  int n_chk, n_fail;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  pwm_multi dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_w(input logic [5:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_r(input logic [5:0] a, input logic [31:0] e, input string tag);
    rd = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int ch, input int n, input int exp, input string tag);
    int hc = 0;
    for (int i = 0; i < n; i++) begin
      hc += int'(pwm[ch]);
      @(negedge clk);
    end
    chk(tag, hc, exp);
  endtask

  // scoreboard monitor: read data is compared one cycle after the strobe
  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= rd;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, int'(rdata), int'(e));
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 outputs low", int'(pwm), 0);
    bus_r(6'd0, 32'd0, "R1 running mask");
    bus_r(6'd2, 32'd0, "R1 status");

    // channel 0: prescale 16, period 10, duty 3, configured while stopped
    bus_w(6'd8, 32'd4);
    bus_w(6'd9, 32'd10);
    bus_w(6'd10, 32'd3);
    bus_r(6'd9, 32'd10, "R6 direct period");
    bus_r(6'd10, 32'd3, "R6 direct duty");
    bus_w(6'd0, 32'd1);
    bus_r(6'd0, 32'd1, "R2 start ch0");
    bus_w(6'd10, 32'd7);
    bus_w(6'd8, 32'h102);
    bus_r(6'd10, 32'd3, "R7 duty write ignored");
    bus_r(6'd8, 32'd4, "R7 pres/pol ignored");
    bus_w(6'd11, 32'd5);
    bus_r(6'd10, 32'd3, "R8 duty reload held");
    bus_r(6'd2, 32'd0, "R9 no flag before wrap");
    idle(200);
    bus_r(6'd2, 32'd1, "R9 flag after wrap");
    bus_r(6'd2, 32'd0, "R9 cleared by read");
    bus_r(6'd10, 32'd5, "R8 duty reloaded");
    count_high(0, 320, 160, "R4 prescaled waveform");

    // period reload through target bit
    bus_w(6'd8, 32'h404);
    bus_w(6'd11, 32'd20);
    bus_r(6'd9, 32'd10, "R8 period reload held");
    idle(400);
    bus_r(6'd2, 32'd1, "R9 period flag");
    bus_r(6'd9, 32'd20, "R8 period reloaded");
    count_high(0, 640, 160, "R3 new period waveform");
    bus_w(6'd11, 32'd30);
    bus_w(6'd11, 32'd12);
    idle(700);
    bus_r(6'd9, 32'd12, "R8 later reload replaces");
    bus_r(6'd2, 32'd1, "R9 flag after replace");

    // stop with a reload held
    bus_w(6'd11, 32'd25);
    bus_w(6'd1, 32'd1);
    bus_r(6'd0, 32'd0, "R2 stop ch0");
    idle(400);
    bus_r(6'd9, 32'd12, "R10 held reload dropped");
    bus_r(6'd2, 32'd0, "R10 no flag");
    chk("R2 idle level", int'(pwm[0]), 0);

    // channel 1: inverted polarity
    bus_w(6'd12, 32'h100);
    idle(1);
    chk("R5 inverted idle", int'(pwm[1]), 1);
    bus_w(6'd13, 32'd8);
    bus_w(6'd14, 32'd2);
    bus_w(6'd0, 32'd2);
    count_high(1, 16, 12, "R5 inverted waveform");
    bus_w(6'd12, 32'd0);
    bus_r(6'd12, 32'h100, "R7 polarity locked");
    count_high(1, 16, 12, "R7 waveform unchanged");

    // channel 2: duty extremes
    bus_w(6'd17, 32'd6);
    bus_w(6'd18, 32'd0);
    bus_w(6'd0, 32'd4);
    count_high(2, 12, 0, "R3 duty zero");
    bus_w(6'd1, 32'd4);
    bus_w(6'd18, 32'd9);
    bus_w(6'd0, 32'd4);
    count_high(2, 12, 12, "R3 duty above period");

    // channel 3: clamp and direct reload while stopped
    bus_w(6'd20, 32'd15);
    bus_r(6'd20, 32'd10, "R4 prescale clamp");
    bus_w(6'd20, 32'd0);
    bus_w(6'd23, 32'd4);
    bus_r(6'd22, 32'd4, "R6 direct reload");
    bus_r(6'd2, 32'd0, "R9 no flag when stopped");

    wait (exp_q.size() == 0);
    idle(2);
    finish_run();
  end
endmodule